// File: doc/BRIEF.md
# Cross-Domain Doorbell Interrupt Unit

This block sits inside a bridge that joins two processor domains, called primary and secondary here. Each domain owns a doorbell: a 16-bit request vector paired with a 16-bit mask. Either domain's register port can reach both doorbells. A processor rings the other side by setting request bits, and the receiving side acknowledges by clearing them. Each side drives a level interrupt that is high while any unmasked request bit is pending. Each side also drives one-cycle rise and fall pulses on every change of that level, which downstream logic turns into interrupt messages.

Eight shared scratchpad words are also reachable from both ports. They carry mailbox data that goes with a doorbell. Access to them never touches an interrupt. Each register port is a plain valid/write/address/data interface, and read data returns one cycle after the request.

Top module: `xdom_doorbell`

## Requirements
- R1: After reset, every request bit is 0, every mask bit is 1, every scratchpad word is 0, both interrupt levels are low and no event pulse is active.
- R2: A side's interrupt level is high exactly when at least one of its request bits is 1 while the same mask bit is 0. The level changes in the first cycle after the clock edge that accepted the write.
- R3: A side's interrupt level stays high until every pending unmasked request bit has been either cleared or masked.
- R4: Word address 0 (primary) or 4 (secondary) sets request bits, and address 1 or 5 clears them. A read at either address of a side returns that side's request vector in data bits 15:0, with upper bits zero.
- R5: Address 2 (primary) or 6 (secondary) sets mask bits, and address 3 or 7 clears them. Both addresses of a side act on one mask register, and a read at either returns it.
- R6: Both the primary and the secondary register ports can read and write all doorbell addresses of both sides. A write to one side never alters the other side.
- R7: Each low-to-high change of a side's level produces a one-cycle pulse on its rise output, in the same cycle the level goes high. Each high-to-low change produces a one-cycle pulse on its fall output.
- R8: Addresses 8 to 15 select scratchpad words 0 to 7, readable and writable as 32-bit words from both ports. Scratchpad accesses never change any interrupt level or event output.
- R9: Doorbell writes are write-one: a 1 in write data bit i acts on bit i, and a 0 leaves bit i unchanged.
- R10: When both ports write in the same cycle, the primary write is applied before the secondary one. So for the same scratchpad word the secondary data is kept. If a set and a clear hit the same request or mask bit at once, the bit ends up set.
- R11: A read accepted at a clock edge returns its data with rvalid high in the following cycle. The data reflects register contents from before any write accepted at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pri_valid_i | input | 1 | Primary port access request |
| pri_write_i | input | 1 | Primary port: 1 write, 0 read |
| pri_addr_i | input | 4 | Primary port word address |
| pri_wdata_i | input | 32 | Primary port write data |
| pri_rvalid_o | output | 1 | Primary port read data valid |
| pri_rdata_o | output | 32 | Primary port read data |
| sec_valid_i | input | 1 | Secondary port access request |
| sec_write_i | input | 1 | Secondary port: 1 write, 0 read |
| sec_addr_i | input | 4 | Secondary port word address |
| sec_wdata_i | input | 32 | Secondary port write data |
| sec_rvalid_o | output | 1 | Secondary port read data valid |
| sec_rdata_o | output | 32 | Secondary port read data |
| pri_irq_o | output | 1 | Primary side interrupt level |
| pri_irq_rise_o | output | 1 | Primary side level went high (one cycle) |
| pri_irq_fall_o | output | 1 | Primary side level went low (one cycle) |
| sec_irq_o | output | 1 | Secondary side interrupt level |
| sec_irq_rise_o | output | 1 | Secondary side level went high (one cycle) |
| sec_irq_fall_o | output | 1 | Secondary side level went low (one cycle) |

## Verification
The hardest case to reach is two ports hitting one register in the same cycle: a set from one port against a clear from the other, or two scratchpad writes to the same word. A read racing a write to the word it reads is similar. The stimulus reaches these by driving both ports in one cycle through a single driver task. That task predicts the outcome from the precedence rule before the edge and checks the result afterwards. Event pulses are checked both in the cycle of each level change and again one cycle later, to show they last exactly one cycle.

// File: rtl/xdom_pkg.sv
`timescale 1ns/1ps
package xdom_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned SP_IDX_W = 3;
  localparam int unsigned SP_N     = 1 << SP_IDX_W;
  localparam int unsigned N_SIDE   = 2;
  localparam int unsigned N_PORT   = 2;

  typedef enum logic [1:0] {
    OP_REQ_SET = 2'd0,
    OP_REQ_CLR = 2'd1,
    OP_MSK_SET = 2'd2,
    OP_MSK_CLR = 2'd3
  } db_op_e;

  typedef struct packed {
    logic                is_sp;
    logic                side;
    db_op_e              op;
    logic [SP_IDX_W-1:0] sp_idx;
  } addr_dec_t;

  function automatic addr_dec_t dec_addr(input logic [ADDR_W-1:0] a);
    addr_dec_t d;
    d.is_sp  = a[ADDR_W-1];
    d.side   = a[ADDR_W-2];
    d.op     = db_op_e'(a[1:0]);
    d.sp_idx = a[SP_IDX_W-1:0];
    return d;
  endfunction
endpackage

// File: rtl/xdom_port_dec.sv
`timescale 1ns/1ps
module xdom_port_dec
  import xdom_pkg::*;
#(
  parameter int unsigned DB_W   = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic                             valid_i,
  input  logic                             write_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [N_SIDE-1:0][DB_W-1:0]      req_set_o,
  output logic [N_SIDE-1:0][DB_W-1:0]      req_clr_o,
  output logic [N_SIDE-1:0][DB_W-1:0]      msk_set_o,
  output logic [N_SIDE-1:0][DB_W-1:0]      msk_clr_o,
  output logic                             sp_we_o,
  output logic [SP_IDX_W-1:0]              sp_idx_o,
  output logic [DATA_W-1:0]                sp_wdata_o
);
  addr_dec_t dec;
  logic      wr;

  assign dec        = dec_addr(addr_i);
  assign wr         = valid_i & write_i;
  assign sp_we_o    = wr & dec.is_sp;
  assign sp_idx_o   = dec.sp_idx;
  assign sp_wdata_o = wdata_i;

  always_comb begin
    req_set_o = '0;
    req_clr_o = '0;
    msk_set_o = '0;
    msk_clr_o = '0;
    for (int s = 0; s < N_SIDE; s++) begin
      if (wr && !dec.is_sp && (dec.side == s[0])) begin
        unique case (dec.op)
          OP_REQ_SET: req_set_o[s] = wdata_i[DB_W-1:0];
          OP_REQ_CLR: req_clr_o[s] = wdata_i[DB_W-1:0];
          OP_MSK_SET: msk_set_o[s] = wdata_i[DB_W-1:0];
          OP_MSK_CLR: msk_clr_o[s] = wdata_i[DB_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xdom_db_side.sv
`timescale 1ns/1ps
module xdom_db_side #(
  parameter int unsigned DB_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DB_W-1:0] req_set_i,
  input  logic [DB_W-1:0] req_clr_i,
  input  logic [DB_W-1:0] msk_set_i,
  input  logic [DB_W-1:0] msk_clr_i,
  output logic [DB_W-1:0] req_o,
  output logic [DB_W-1:0] msk_o,
  output logic            irq_o,
  output logic            rise_o,
  output logic            fall_o
);
  logic [DB_W-1:0] req_q, msk_q;
  logic            lvl_q;

  // set applied after clear: set wins on a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      msk_q <= '1;
      lvl_q <= 1'b0;
    end else begin
      req_q <= (req_q & ~req_clr_i) | req_set_i;
      msk_q <= (msk_q & ~msk_clr_i) | msk_set_i;
      lvl_q <= irq_o;
    end
  end

  assign irq_o  = |(req_q & ~msk_q);
  assign rise_o = irq_o & ~lvl_q;
  assign fall_o = ~irq_o & lvl_q;
  assign req_o  = req_q;
  assign msk_o  = msk_q;
endmodule

// File: rtl/xdom_scratch.sv
`timescale 1ns/1ps
module xdom_scratch
  import xdom_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [N_PORT-1:0]                    we_i,
  input  logic [N_PORT-1:0][SP_IDX_W-1:0]      idx_i,
  input  logic [N_PORT-1:0][DATA_W-1:0]        wdata_i,
  output logic [SP_N-1:0][DATA_W-1:0]          sp_o
);
  logic [SP_N-1:0][DATA_W-1:0] sp_q;

  // port order is precedence: higher index lands last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
    end else begin
      for (int p = 0; p < N_PORT; p++) begin
        if (we_i[p]) sp_q[idx_i[p]] <= wdata_i[p];
      end
    end
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/xdom_doorbell.sv
`timescale 1ns/1ps
module xdom_doorbell
  import xdom_pkg::*;
#(
  parameter int unsigned DB_W   = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pri_valid_i,
  input  logic              pri_write_i,
  input  logic [ADDR_W-1:0] pri_addr_i,
  input  logic [DATA_W-1:0] pri_wdata_i,
  output logic              pri_rvalid_o,
  output logic [DATA_W-1:0] pri_rdata_o,
  input  logic              sec_valid_i,
  input  logic              sec_write_i,
  input  logic [ADDR_W-1:0] sec_addr_i,
  input  logic [DATA_W-1:0] sec_wdata_i,
  output logic              sec_rvalid_o,
  output logic [DATA_W-1:0] sec_rdata_o,
  output logic              pri_irq_o,
  output logic              pri_irq_rise_o,
  output logic              pri_irq_fall_o,
  output logic              sec_irq_o,
  output logic              sec_irq_rise_o,
  output logic              sec_irq_fall_o
);
  logic [N_PORT-1:0]                   p_valid, p_write, p_rvalid;
  logic [N_PORT-1:0][ADDR_W-1:0]       p_addr;
  logic [N_PORT-1:0][DATA_W-1:0]       p_wdata, p_rdata;

  logic [N_PORT-1:0][N_SIDE-1:0][DB_W-1:0] d_req_set, d_req_clr, d_msk_set, d_msk_clr;
  logic [N_PORT-1:0]                       sp_we;
  logic [N_PORT-1:0][SP_IDX_W-1:0]         sp_idx;
  logic [N_PORT-1:0][DATA_W-1:0]           sp_wdata;

  logic [N_SIDE-1:0][DB_W-1:0] req_set, req_clr, msk_set, msk_clr;
  logic [N_SIDE-1:0][DB_W-1:0] req_v, msk_v;
  logic [N_SIDE-1:0]           irq, rise, fall;
  logic [SP_N-1:0][DATA_W-1:0] sp_v;

  // port 0 = primary, port 1 = secondary (precedence order)
  assign p_valid = {sec_valid_i, pri_valid_i};
  assign p_write = {sec_write_i, pri_write_i};
  assign p_addr  = {sec_addr_i, pri_addr_i};
  assign p_wdata = {sec_wdata_i, pri_wdata_i};

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;
    addr_dec_t         rdec;

    xdom_port_dec #(.DB_W(DB_W), .DATA_W(DATA_W)) u_dec (
      .valid_i   (p_valid[p]),
      .write_i   (p_write[p]),
      .addr_i    (p_addr[p]),
      .wdata_i   (p_wdata[p]),
      .req_set_o (d_req_set[p]),
      .req_clr_o (d_req_clr[p]),
      .msk_set_o (d_msk_set[p]),
      .msk_clr_o (d_msk_clr[p]),
      .sp_we_o   (sp_we[p]),
      .sp_idx_o  (sp_idx[p]),
      .sp_wdata_o(sp_wdata[p])
    );

    assign rdec = dec_addr(p_addr[p]);

    always_comb begin
      rd_mux = '0;
      if (rdec.is_sp)          rd_mux = sp_v[rdec.sp_idx];
      else if (rdec.op[1])     rd_mux[DB_W-1:0] = msk_v[rdec.side];
      else                     rd_mux[DB_W-1:0] = req_v[rdec.side];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rvalid_q <= 1'b0;
        rdata_q  <= '0;
      end else begin
        rvalid_q <= p_valid[p] & ~p_write[p];
        if (p_valid[p] && !p_write[p]) rdata_q <= rd_mux;
      end
    end

    assign p_rvalid[p] = rvalid_q;
    assign p_rdata[p]  = rdata_q;
  end

  always_comb begin
    req_set = '0;
    req_clr = '0;
    msk_set = '0;
    msk_clr = '0;
    for (int p = 0; p < N_PORT; p++) begin
      for (int s = 0; s < N_SIDE; s++) begin
        req_set[s] |= d_req_set[p][s];
        req_clr[s] |= d_req_clr[p][s];
        msk_set[s] |= d_msk_set[p][s];
        msk_clr[s] |= d_msk_clr[p][s];
      end
    end
  end

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    xdom_db_side #(.DB_W(DB_W)) u_side (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_set_i(req_set[s]),
      .req_clr_i(req_clr[s]),
      .msk_set_i(msk_set[s]),
      .msk_clr_i(msk_clr[s]),
      .req_o    (req_v[s]),
      .msk_o    (msk_v[s]),
      .irq_o    (irq[s]),
      .rise_o   (rise[s]),
      .fall_o   (fall[s])
    );
  end

  xdom_scratch #(.DATA_W(DATA_W)) u_scratch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (sp_we),
    .idx_i  (sp_idx),
    .wdata_i(sp_wdata),
    .sp_o   (sp_v)
  );

  assign pri_rvalid_o   = p_rvalid[0];
  assign pri_rdata_o    = p_rdata[0];
  assign sec_rvalid_o   = p_rvalid[1];
  assign sec_rdata_o    = p_rdata[1];
  assign pri_irq_o      = irq[0];
  assign pri_irq_rise_o = rise[0];
  assign pri_irq_fall_o = fall[0];
  assign sec_irq_o      = irq[1];
  assign sec_irq_rise_o = rise[1];
  assign sec_irq_fall_o = fall[1];
endmodule

// File: rtl/xdom_doorbell_chk.sv
`timescale 1ns/1ps
module xdom_doorbell_chk
  import xdom_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pri_valid_i,
  input logic              pri_write_i,
  input logic [ADDR_W-1:0] pri_addr_i,
  input logic              sec_valid_i,
  input logic              sec_write_i,
  input logic [ADDR_W-1:0] sec_addr_i,
  input logic              pri_rvalid_o,
  input logic              sec_rvalid_o,
  input logic              pri_irq_o,
  input logic              pri_irq_rise_o,
  input logic              pri_irq_fall_o,
  input logic              sec_irq_o,
  input logic              sec_irq_rise_o,
  input logic              sec_irq_fall_o
);
  logic db_wr;
  assign db_wr = (pri_valid_i & pri_write_i & ~pri_addr_i[ADDR_W-1]) |
                 (sec_valid_i & sec_write_i & ~sec_addr_i[ADDR_W-1]);

  p_pri_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pri_irq_o) |-> pri_irq_rise_o);
  p_pri_rise_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_irq_rise_o |-> (pri_irq_o && !$past(pri_irq_o)));
  p_pri_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pri_irq_o) |-> pri_irq_fall_o);
  p_sec_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_irq_o) |-> sec_irq_rise_o);
  p_sec_fall_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_irq_fall_o |-> (!sec_irq_o && $past(sec_irq_o)));
  p_no_dual_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pri_irq_rise_o && pri_irq_fall_o) && !(sec_irq_rise_o && sec_irq_fall_o));
  p_quiet_without_db_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !db_wr |=> ($stable(pri_irq_o) && $stable(sec_irq_o)));
  p_pri_rd_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_valid_i && !pri_write_i) |=> pri_rvalid_o);
  p_sec_rd_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sec_valid_i && !sec_write_i) |=> !sec_rvalid_o);
endmodule

bind xdom_doorbell xdom_doorbell_chk u_chk (.*);

// File: tb/tb_xdom_doorbell.sv
`timescale 1ns/1ps
module tb_xdom_doorbell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pv = 0, pw = 0, sv = 0, sw = 0;
  logic [3:0]  pa = 0, sa = 0;
  logic [31:0] pd = 0, sd = 0;
  logic        p_rv, s_rv;
  logic [31:0] p_rd, s_rd;
  logic        p_irq, p_rise, p_fall, s_irq, s_rise, s_fall;

  always #4 clk = ~clk;

  xdom_doorbell dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pri_valid_i(pv), .pri_write_i(pw), .pri_addr_i(pa), .pri_wdata_i(pd),
    .pri_rvalid_o(p_rv), .pri_rdata_o(p_rd),
    .sec_valid_i(sv), .sec_write_i(sw), .sec_addr_i(sa), .sec_wdata_i(sd),
    .sec_rvalid_o(s_rv), .sec_rdata_o(s_rd),
    .pri_irq_o(p_irq), .pri_irq_rise_o(p_rise), .pri_irq_fall_o(p_fall),
    .sec_irq_o(s_irq), .sec_irq_rise_o(s_rise), .sec_irq_fall_o(s_fall)
  );

  int n_vec = 0, n_bad = 0;
  logic [15:0] m_req [2];
  logic [15:0] m_msk [2];
  logic [31:0] m_sp  [8];
  logic [31:0] q_dat [2][$];
  string       q_tag [2][$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] a);
    if (a[3]) return m_sp[a[2:0]];
    if (a[1]) return {16'h0, m_msk[a[2]]};
    return {16'h0, m_req[a[2]]};
  endfunction

  function automatic logic m_lvl(input int s);
    return |(m_req[s] & ~m_msk[s]);
  endfunction

  // set/clear collected from both ports, set applied last; scratch primary then secondary
  task automatic m_apply(input logic w0, input logic [3:0] a0, input logic [31:0] d0,
                         input logic w1, input logic [3:0] a1, input logic [31:0] d1);
    logic [15:0] rs [2], rc [2], ms [2], mc [2];
    logic        w [2];
    logic [3:0]  a [2];
    logic [31:0] d [2];
    w[0] = w0; a[0] = a0; d[0] = d0; w[1] = w1; a[1] = a1; d[1] = d1;
    for (int s = 0; s < 2; s++) begin rs[s] = 0; rc[s] = 0; ms[s] = 0; mc[s] = 0; end
    for (int p = 0; p < 2; p++) begin
      if (w[p] && !a[p][3]) begin
        case (a[p][1:0])
          2'd0: rs[a[p][2]] |= d[p][15:0];
          2'd1: rc[a[p][2]] |= d[p][15:0];
          2'd2: ms[a[p][2]] |= d[p][15:0];
          default: mc[a[p][2]] |= d[p][15:0];
        endcase
      end
    end
    for (int s = 0; s < 2; s++) begin
      m_req[s] = (m_req[s] & ~rc[s]) | rs[s];
      m_msk[s] = (m_msk[s] & ~mc[s]) | ms[s];
    end
    for (int p = 0; p < 2; p++) if (w[p] && a[p][3]) m_sp[a[p][2:0]] = d[p];
  endtask

  // driver: one access cycle on either or both ports, then check interrupt outputs
  task automatic cyc(input logic v0, input logic w0, input logic [3:0] a0, input logic [31:0] d0,
                     input logic v1, input logic w1, input logic [3:0] a1, input logic [31:0] d1,
                     input string tag);
    logic old [2];
    @(negedge clk);
    chk("R7", {30'h0, p_rise, p_fall}, 32'h0, "pri pulse lasts one cycle");
    chk("R7", {30'h0, s_rise, s_fall}, 32'h0, "sec pulse lasts one cycle");
    if (v0 && !w0) begin q_dat[0].push_back(m_read(a0)); q_tag[0].push_back(tag); end
    if (v1 && !w1) begin q_dat[1].push_back(m_read(a1)); q_tag[1].push_back(tag); end
    pv = v0; pw = w0; pa = a0; pd = d0;
    sv = v1; sw = w1; sa = a1; sd = d1;
    old[0] = m_lvl(0); old[1] = m_lvl(1);
    m_apply(v0 & w0, a0, d0, v1 & w1, a1, d1);
    @(negedge clk);
    pv = 0; sv = 0;
    chk(tag, {29'h0, p_irq, p_rise, p_fall},
        {29'h0, m_lvl(0), m_lvl(0) & ~old[0], ~m_lvl(0) & old[0]}, "pri irq/rise/fall");
    chk(tag, {29'h0, s_irq, s_rise, s_fall},
        {29'h0, m_lvl(1), m_lvl(1) & ~old[1], ~m_lvl(1) & old[1]}, "sec irq/rise/fall");
  endtask

  task automatic wr(input int port, input logic [3:0] a, input logic [31:0] d, input string tag);
    if (port == 0) cyc(1, 1, a, d, 0, 0, 0, 0, tag);
    else           cyc(0, 0, 0, 0, 1, 1, a, d, tag);
  endtask

  task automatic rd(input int port, input logic [3:0] a, input string tag);
    if (port == 0) cyc(1, 0, a, 0, 0, 0, 0, 0, tag);
    else           cyc(0, 0, 0, 0, 1, 0, a, 0, tag);
  endtask

  // monitor: pop expected read data as each port returns it
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_rv) begin
        if (q_dat[0].size() == 0) begin n_vec++; n_bad++; $display("FAIL R11 pri unexpected rvalid: actual 1 expected 0"); end
        else chk(q_tag[0].pop_front(), p_rd, q_dat[0].pop_front(), "pri rdata");
      end
      if (s_rv) begin
        if (q_dat[1].size() == 0) begin n_vec++; n_bad++; $display("FAIL R11 sec unexpected rvalid: actual 1 expected 0"); end
        else chk(q_tag[1].pop_front(), s_rd, q_dat[1].pop_front(), "sec rdata");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin m_req[s] = '0; m_msk[s] = '1; end
    for (int i = 0; i < 8; i++) m_sp[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {26'h0, p_irq, p_rise, p_fall, s_irq, s_rise, s_fall}, 32'h0, "irq outputs in reset");
    rst_n = 1'b1;
    // R1: all registers at reset value, read from both ports
    for (int a = 0; a < 16; a++) rd(a % 2, 4'(a), "R1");
    // R2: masked request does not interrupt
    wr(0, 4'd0, 32'h0000_0005, "R2");
    rd(1, 4'd1, "R4");
    rd(0, 4'd0, "R4");
    // R2/R7: unmask bit 2 from the secondary port -> rise
    wr(1, 4'd3, 32'h0000_0004, "R2");
    rd(0, 4'd2, "R5");
    // R3: clear a masked bit, level stays
    wr(0, 4'd1, 32'h0000_0001, "R3");
    // R3/R7: mask the pending bit -> fall
    wr(0, 4'd2, 32'h0000_0004, "R3");
    rd(1, 4'd3, "R5");
    // unmask everything -> rise again, then clear request -> fall
    wr(1, 4'd3, 32'h0000_FFFF, "R5");
    wr(1, 4'd1, 32'h0000_0004, "R3");
    // R6: secondary side doorbell from primary port; primary side untouched
    wr(0, 4'd4, 32'h0000_8000, "R6");
    wr(1, 4'd7, 32'h0000_8000, "R6");
    rd(0, 4'd5, "R6");
    rd(1, 4'd6, "R6");
    rd(0, 4'd0, "R6");
    // R9: zero data changes nothing
    wr(0, 4'd5, 32'h0000_0000, "R9");
    wr(1, 4'd6, 32'h0000_0000, "R9");
    rd(1, 4'd4, "R9");
    rd(0, 4'd7, "R9");
    // R9: upper data bits ignored on doorbell addresses
    wr(0, 4'd0, 32'hFFFF_0000, "R9");
    rd(0, 4'd0, "R9");
    // R8: scratchpads, both ports, no interrupt effect
    wr(0, 4'd8, 32'hDEAD_BEEF, "R8");
    wr(1, 4'd15, 32'h1234_5678, "R8");
    rd(1, 4'd8, "R8");
    rd(0, 4'd15, "R8");
    for (int i = 0; i < 8; i++) wr(i % 2, 4'(8 + i), 32'hA5A5_0000 | i, "R8");
    for (int i = 0; i < 8; i++) rd((i + 1) % 2, 4'(8 + i), "R8");
    // R10: set from primary vs clear from secondary on same bits -> set wins
    cyc(1, 1, 4'd0, 32'h0000_00F0, 1, 1, 4'd1, 32'h0000_0030, "R10");
    rd(1, 4'd0, "R10");
    // R10: clear from primary vs set from secondary on mask
    cyc(1, 1, 4'd7, 32'h0000_8000, 1, 1, 4'd6, 32'h0000_8000, "R10");
    rd(0, 4'd6, "R10");
    // R10: same scratchpad word from both ports -> secondary data kept
    cyc(1, 1, 4'd10, 32'h1111_1111, 1, 1, 4'd10, 32'h2222_2222, "R10");
    rd(0, 4'd10, "R10");
    // R11: read racing a write to the same word returns the old value
    cyc(1, 0, 4'd10, 0, 1, 1, 4'd10, 32'h3333_3333, "R11");
    cyc(1, 1, 4'd0, 32'h0000_0F00, 1, 0, 4'd0, 0, "R11");
    rd(1, 4'd10, "R11");
    rd(0, 4'd0, "R11");
    // tidy: clear all requests on both sides
    cyc(1, 1, 4'd1, 32'h0000_FFFF, 1, 1, 4'd5, 32'h0000_FFFF, "R3");
    repeat (3) @(negedge clk);
    chk("R11", 32'(q_dat[0].size() + q_dat[1].size()), 32'h0, "outstanding reads");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule